// File: doc/BRIEF.md
# Pseudo-static RAM bus timing monitor

This block sits beside the asynchronous interface of a pseudo-static RAM and watches the controller's traffic. It never drives the memory. It samples the chip selects, write and output enables, byte enables, the address bus and the controller's own data-drive enable on a fast clock. Every interval is measured as a count of sample periods, compared against limits derived from the sample-clock frequency and the nanosecond parameters.

It catches three kinds of misuse. The first is a write strobe that is too short. The second is the controller driving the data lines while the memory is also driving them for a read. The third is refresh starvation: the memory hides its refresh inside read cycles, so a long train of read cycles shorter than the minimum cycle time starves it. This is an error when the train lasts the starvation window with no long enough chip-select-high gap and no full-length read. Each class has a sticky flag. A saturating counter totals all violation samples, and one clear input resets both the flags and the counter.

The starvation tracker is a four-state machine. OFF means the chip is deselected. CLEAN means it is selected with no pending short cycles. SHORT means short cycles are occurring and the window timer runs. STARVED means the window has expired. The transitions are:

- OFF to CLEAN: the primary select goes low. OFF goes straight to SHORT if a short cycle occurs in that same sample.
- CLEAN to SHORT: a short cycle occurs.
- SHORT to CLEAN, and STARVED to CLEAN: a read reaches full length.
- SHORT to STARVED: the timer expires. The starvation error comes from this transition.
- Any state to OFF: the primary select stays high for a full read-cycle time.

Top module: `psram_bus_monitor`

## Requirements
- R1: After reset all three error flags are 0 and `viol_cnt` is 0.
- R2: A write is active while `ce1_n`=0, `ce2`=1, `we_n`=0 and at least one of `ble_n`/`bhe_n` is 0. A write active for fewer than WP_CYC samples (8 by default: 40 ns at 200 MHz) sets `wp_err`. A write of WP_CYC samples or more does not.
- R3: A write ends at the first of its qualifying signals to go inactive. A write ended early by `ce1_n` rising sets `wp_err`. `we_n` low with both byte enables high is not a write and sets nothing.
- R4: The memory drives the data bus when `ce1_n`=0, `ce2`=1, `we_n`=1, `oe_n`=0 and a byte enable is low. `host_drv`=1 in such a sample sets `bus_err`. `host_drv`=1 with `oe_n`=1, or with both byte enables high, does not.
- R5: During a read (`ce1_n`=0, `ce2`=1, `we_n`=1), an address change after fewer than RC_CYC samples (11 by default: 55 ns) is a short cycle. Short cycles sustained for STARVE_CYC samples (3000 by default: 15 us) set `starve_err`.
- R6: `ce1_n` high for RC_CYC consecutive samples restarts the starvation window. A shorter high gap does not.
- R7: During a read, an address held for RC_CYC samples restarts the starvation window.
- R8: Flags are sticky until `clr`=1. A clear zeroes all flags and `viol_cnt` on the next edge. A violation in the clearing sample is still recorded.
- R9: `viol_cnt` adds one per violation per sample and saturates at 2^CNT_W-1 (255 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce1_n | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Secondary chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ble_n | input | 1 | Lower byte enable, active low |
| bhe_n | input | 1 | Upper byte enable, active low |
| addr | input | AW | Word address bus |
| host_drv | input | 1 | Controller is driving the data lines |
| clr | input | 1 | Clear flags and counter |
| wp_err | output | 1 | Sticky short write-pulse flag |
| bus_err | output | 1 | Sticky data-bus contention flag |
| starve_err | output | 1 | Sticky refresh-starvation flag |
| viol_cnt | output | CNT_W | Saturating violation count |

## Verification
A starvation state machine stuck in CLEAN or OFF shows no error at all, even after a full window of short cycles. One that fails to leave SHORT on a qualifying gap or a full-length read raises `starve_err` about STARVE_CYC samples later. So window restarts are tested by bracketing the limit on both sides. A pulse-width counter off by one shows up only at the WP_CYC-1 and WP_CYC boundary. Tally faults appear within one sample in `viol_cnt` and in the sticky flags.

// File: rtl/psram_mon_pkg.sv
package psram_mon_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_CLEAN,
        ST_SHORT,
        ST_STARVED
    } starve_st_t;

    typedef struct packed {
        logic wp;
        logic bus;
        logic starve;
    } viol_t;
endpackage

// File: rtl/pm_write_width.sv
module pm_write_width #(
    parameter int WP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    output logic evt
);
    localparam int WW = $clog2(WP_CYC + 1);
    localparam logic [WW-1:0] WP_LIM = WW'(WP_CYC);

    logic          act_q;
    logic [WW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            len_q <= '0;
        end else begin
            act_q <= wr_act;
            if (!wr_act)
                len_q <= '0;
            else if (len_q != WP_LIM)
                len_q <= len_q + 1'b1;
        end
    end

    // a write just ended with fewer active samples than the minimum
    assign evt = act_q && !wr_act && (len_q < WP_LIM);
endmodule

// File: rtl/pm_starve_fsm.sv
module pm_starve_fsm
    import psram_mon_pkg::*;
#(
    parameter int AW         = 19,
    parameter int RC_CYC     = 11,
    parameter int STARVE_CYC = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          rd_sel,
    input  logic [AW-1:0] addr,
    output logic          evt
);
    localparam int SW = $clog2(RC_CYC + 1);
    localparam int TW = $clog2(STARVE_CYC + 1);
    localparam logic [SW-1:0] RC_LIM  = SW'(RC_CYC);
    localparam logic [TW-1:0] TMR_END = TW'(STARVE_CYC - 1);

    starve_st_t    st_q, st_d;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] stab_q;
    logic [SW-1:0] hi_q;
    logic [TW-1:0] tmr_q;

    logic chg, short_evt, norm_evt, gap_evt;
    assign chg       = addr != addr_q;
    assign short_evt = rd_sel && chg && (stab_q < RC_LIM);
    assign norm_evt  = rd_sel && !chg && (stab_q == RC_LIM - 1'b1);
    assign gap_evt   = ce1_n && (hi_q == RC_LIM - 1'b1);

    // interval counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            stab_q <= RC_LIM;
            hi_q   <= '0;
            tmr_q  <= '0;
        end else begin
            addr_q <= addr;
            if (chg)
                stab_q <= SW'(1);
            else if (stab_q != RC_LIM)
                stab_q <= stab_q + 1'b1;
            if (!ce1_n)
                hi_q <= '0;
            else if (hi_q != RC_LIM)
                hi_q <= hi_q + 1'b1;
            tmr_q <= (st_q == ST_SHORT && st_d == ST_SHORT) ? tmr_q + 1'b1 : '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (short_evt)   st_d = ST_SHORT;
                else if (!ce1_n) st_d = ST_CLEAN;
            end
            ST_CLEAN: begin
                if (gap_evt)        st_d = ST_OFF;
                else if (short_evt) st_d = ST_SHORT;
            end
            ST_SHORT: begin
                if (gap_evt)               st_d = ST_OFF;
                else if (norm_evt)         st_d = ST_CLEAN;
                else if (tmr_q == TMR_END) st_d = ST_STARVED;
            end
            ST_STARVED: begin
                if (gap_evt)       st_d = ST_OFF;
                else if (norm_evt) st_d = ST_CLEAN;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= (st_q == ST_SHORT) && (st_d == ST_STARVED);
    end
endmodule

// File: rtl/pm_tally.sv
module pm_tally
    import psram_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  viol_t            ev,
    output viol_t            flags,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] base, sum;
    assign base = clr ? '0 : {1'b0, cnt};
    assign sum  = base + (CNT_W+1)'(ev.wp) + (CNT_W+1)'(ev.bus)
                       + (CNT_W+1)'(ev.starve);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            cnt   <= '0;
        end else begin
            flags <= (clr ? viol_t'('0) : flags) | ev;
            cnt   <= (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/psram_bus_monitor.sv
module psram_bus_monitor
    import psram_mon_pkg::*;
#(
    parameter int AW          = 19,
    parameter int CLK_MHZ     = 200,
    parameter int T_RC_NS     = 55,
    parameter int T_WP_NS     = 40,
    parameter int T_STARVE_NS = 15000,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             ble_n,
    input  logic             bhe_n,
    input  logic [AW-1:0]    addr,
    input  logic             host_drv,
    input  logic             clr,
    output logic             wp_err,
    output logic             bus_err,
    output logic             starve_err,
    output logic [CNT_W-1:0] viol_cnt
);
    localparam int RC_CYC     = (T_RC_NS * CLK_MHZ + 999) / 1000;
    localparam int WP_CYC     = (T_WP_NS * CLK_MHZ + 999) / 1000;
    localparam int STARVE_CYC = (T_STARVE_NS / 1000) * CLK_MHZ;

    logic sel, any_byte, wr_act, rd_sel, mem_drv;
    assign sel      = !ce1_n && ce2;
    assign any_byte = !ble_n || !bhe_n;
    assign wr_act   = sel && !we_n && any_byte;
    assign rd_sel   = sel && we_n;
    assign mem_drv  = rd_sel && !oe_n && any_byte;

    viol_t ev, flags;
    logic  ev_any;

    pm_write_width #(.WP_CYC(WP_CYC)) u_wp (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .evt(ev.wp)
    );

    pm_starve_fsm #(.AW(AW), .RC_CYC(RC_CYC), .STARVE_CYC(STARVE_CYC)) u_st (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .rd_sel(rd_sel),
        .addr(addr), .evt(ev.starve)
    );

    assign ev.bus = mem_drv && host_drv;
    assign ev_any = |ev;

    pm_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ev(ev),
        .flags(flags), .cnt(viol_cnt)
    );

    assign wp_err     = flags.wp;
    assign bus_err    = flags.bus;
    assign starve_err = flags.starve;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ce1_n,
    input logic             ce2,
    input logic             we_n,
    input logic             oe_n,
    input logic             ble_n,
    input logic             bhe_n,
    input logic             host_drv,
    input logic             ev_any,
    input logic             wp_err,
    input logic             bus_err,
    input logic             starve_err,
    input logic [CNT_W-1:0] viol_cnt
);
    // R4: a driving controller during a memory read is always flagged
    p_contend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_drv && !ce1_n && ce2 && we_n && !oe_n && (!ble_n || !bhe_n))
        |=> bus_err);

    // R8: flags hold until cleared
    p_sticky_wp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err && !clr) |=> wp_err);
    p_sticky_starve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (starve_err && !clr) |=> starve_err);

    // R8: a clear with no concurrent violation empties everything
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_any) |=> (viol_cnt == '0 && !wp_err && !bus_err && !starve_err));

    // R9: saturation and monotonic growth
    p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&viol_cnt && !clr) |=> &viol_cnt);
    p_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> viol_cnt >= $past(viol_cnt));
    p_flag_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err || bus_err || starve_err) |-> viol_cnt != '0);
endmodule

bind psram_bus_monitor pm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ce1_n(ce1_n), .ce2(ce2),
    .we_n(we_n), .oe_n(oe_n), .ble_n(ble_n), .bhe_n(bhe_n),
    .host_drv(host_drv), .ev_any(ev_any), .wp_err(wp_err),
    .bus_err(bus_err), .starve_err(starve_err), .viol_cnt(viol_cnt)
);

// File: tb/sim_psram_bus_monitor.sv
module sim_psram_bus_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic ble_n = 1'b0, bhe_n = 1'b0, host_drv = 1'b0, clr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic wp_err, bus_err, starve_err;
    logic [CNT_W-1:0] viol_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_bus_monitor #(.AW(AW), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n),
        .oe_n(oe_n), .ble_n(ble_n), .bhe_n(bhe_n), .addr(addr),
        .host_drv(host_drv), .clr(clr), .wp_err(wp_err), .bus_err(bus_err),
        .starve_err(starve_err), .viol_cnt(viol_cnt)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_clear();
        ce1_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; host_drv = 1'b0;
        ble_n = 1'b0; bhe_n = 1'b0;
        tick(15);
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    endtask

    task automatic short_run(input int cycles);
        for (int i = 0; i < cycles / 4; i++) begin
            addr = addr + 1'b1;
            tick(4);
        end
    endtask

    task automatic t_reset();
        tick(3); rst_n = 1'b1; tick(2);
        chk("R1 flags after reset", {wp_err, bus_err, starve_err}, 0);
        chk("R1 count after reset", viol_cnt, 0);
    endtask

    task automatic wr_pulse(input int n);
        ce1_n = 1'b0; we_n = 1'b0; tick(n);
        we_n = 1'b1; tick(2);
        ce1_n = 1'b1; tick(1);
    endtask

    task automatic t_write_width();
        wr_pulse(5);
        chk("R2 5-sample write", wp_err, 1);
        chk("R9 one event counted", viol_cnt, 1);
        idle_clear();
        wr_pulse(7);
        chk("R2 7-sample write", wp_err, 1);
        idle_clear();
        wr_pulse(8);
        chk("R2 8-sample write", wp_err, 0);
        wr_pulse(20);
        chk("R2 20-sample write", wp_err, 0);
        idle_clear();
    endtask

    task automatic t_write_term();
        ce1_n = 1'b0; we_n = 1'b0; tick(4);
        ce1_n = 1'b1; tick(2); we_n = 1'b1; tick(1);
        chk("R3 write cut by select", wp_err, 1);
        idle_clear();
        ble_n = 1'b1; bhe_n = 1'b1;
        ce1_n = 1'b0; we_n = 1'b0; tick(4); we_n = 1'b1; tick(2);
        chk("R3 no byte enable is no write", wp_err, 0);
        chk("R3 no byte enable count", viol_cnt, 0);
        idle_clear();
    endtask

    task automatic t_contention();
        ce1_n = 1'b0; oe_n = 1'b1; host_drv = 1'b1; tick(3);
        chk("R4 output disabled", bus_err, 0);
        oe_n = 1'b0; ble_n = 1'b1; bhe_n = 1'b1; tick(3);
        chk("R4 bytes disabled", bus_err, 0);
        bhe_n = 1'b0; tick(1); host_drv = 1'b0; tick(1);
        chk("R4 contention flagged", bus_err, 1);
        chk("R4 single sample count", viol_cnt, 1);
        idle_clear();
        ce1_n = 1'b0; oe_n = 1'b0; host_drv = 1'b1; tick(3);
        host_drv = 1'b0; tick(1);
        chk("R9 three samples counted", viol_cnt, 3);
        idle_clear();
    endtask

    task automatic t_starve_basic();
        ce1_n = 1'b0; oe_n = 1'b0;
        short_run(2900);
        chk("R5 before window", starve_err, 0);
        short_run(200);
        chk("R5 after window", starve_err, 1);
        idle_clear();
    endtask

    task automatic t_gap();
        ce1_n = 1'b0; oe_n = 1'b0;
        short_run(2000);
        ce1_n = 1'b1; tick(12); ce1_n = 1'b0;
        short_run(2000);
        chk("R6 long gap restarts window", starve_err, 0);
        idle_clear();
        ce1_n = 1'b0; oe_n = 1'b0;
        short_run(2000);
        ce1_n = 1'b1; tick(5); ce1_n = 1'b0;
        short_run(1200);
        chk("R6 short gap keeps window", starve_err, 1);
        idle_clear();
    endtask

    task automatic t_normal_read();
        ce1_n = 1'b0; oe_n = 1'b0;
        short_run(2000);
        tick(12);
        short_run(2000);
        chk("R7 full read restarts window", starve_err, 0);
        idle_clear();
    endtask

    task automatic t_sticky_sat();
        ce1_n = 1'b0; oe_n = 1'b0; host_drv = 1'b1; tick(1);
        host_drv = 1'b0; ce1_n = 1'b1; tick(20);
        chk("R8 flag held", bus_err, 1);
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        chk("R8 flag cleared", bus_err, 0);
        chk("R8 count cleared", viol_cnt, 0);
        ce1_n = 1'b0; oe_n = 1'b0; host_drv = 1'b1; tick(300);
        chk("R9 saturated count", viol_cnt, 255);
        clr = 1'b1; tick(1); clr = 1'b0;
        host_drv = 1'b0; tick(1);
        chk("R8 clear with event records it", viol_cnt, 1);
        idle_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_write_width();
        t_write_term();
        t_contention();
        t_starve_basic();
        t_gap();
        t_normal_read();
        t_sticky_sat();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule